// File: doc/BRIEF.md
# Pile-Up Rejection Timing Logic

This block is the per-channel digital decision stage of a pulse-processing front end. It receives a one-cycle strobe when the channel discriminator sees the signal cross threshold, and a second one-cycle strobe when the peak detector finds the pulse maximum. A cycle counter acts as a digital time-to-amplitude converter. It starts at the crossing and defines a timing window whose length is a base count plus a 3-bit trim code times a step count.

A peak that lands inside the window marks a clean single pulse. The block then raises the channel event flag, which stays up until the readout acknowledges it. A peak that lands at or after the window end marks a piled-up pulse. The channel then clears itself at once and raises no flag, so the readout never sees the event and spends no dead time on it. An enable input bypasses the timing test. A timeout returns the channel to idle when a crossing is never followed by a peak.

Top module: `pur_channel`

## Requirements
- R1: After reset the event flag is low and the channel is idle, waiting for a threshold crossing.
- R2: A crossing sampled in idle opens a window whose end is BASE + trim*STEP cycles (default BASE=20, STEP=3, so trim 0 gives 20 and trim 7 gives 41). The elapsed count k is the number of rising edges from the edge that samples the crossing to the edge that samples the peak.
- R3: With enable high, a peak with k below the window end is accepted, and the flag goes high right after the edge that samples the peak.
- R4: With enable high, a peak with k equal to or above the window end is rejected. The flag stays low and the channel is idle on the next cycle, ready for a new crossing.
- R5: The flag holds high until read_i is sampled high, and it is low from the following cycle.
- R6: With enable low, any peak that arrives while the window is open is accepted, whatever its timing, including k equal to TIMEOUT.
- R7: When no peak has arrived by k = TIMEOUT (default 64), the channel returns to idle. A later peak is ignored.
- R8: A crossing that arrives while a window is open, or while the flag is high, is ignored. It neither restarts the count nor opens a new window after the read.
- R9: A peak strobe while the channel is idle is ignored.
- R10: The trim code is captured at the crossing. Changing it while the window is open does not move that window's end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cross_i | input | 1 | One-cycle threshold-crossing strobe |
| peak_i | input | 1 | One-cycle peak-found strobe |
| trim_i | input | 3 | Window extension code, sampled at the crossing |
| enable_i | input | 1 | High: apply the timing test; low: accept every peak |
| read_i | input | 1 | Readout acknowledge that clears the flag |
| flag_o | output | 1 | Channel event flag: an accepted pulse is waiting |

## Verification
Assertions check on every cycle that:
- the flag only rises right after a peak strobe;
- a late peak with enable high never leaves a flag and always returns the channel to idle;
- a raised flag survives every cycle without a read;
- a peak with enable low is always accepted;
- an expired count always leads to idle;
- the captured window end stays within its legal range.

Only the bench scenarios can show the exact acceptance boundary at k = end-1 versus k = end for several trim codes. The same holds for three further behaviours. A crossing ignored while open or while held leaves no trace after the read. A trim change after the crossing has no effect. The channel is again usable right after a rejection or a timeout.

// File: rtl/pur_pkg.sv
`timescale 1ns/1ps
package pur_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPEN = 2'd1,
        ST_HOLD = 2'd2
    } pur_state_e;

    typedef struct packed {
        pur_state_e state;
        logic       flag;
    } pur_ctrl_t;
endpackage

// File: rtl/pur_timer.sv
`timescale 1ns/1ps
module pur_timer #(
    parameter int TIMEOUT = 64,
    parameter int CNT_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expired_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (start_i) begin
            nxt_d.cnt = CNT_W'(1);
        end else if (run_i && cur_q.cnt != LIMIT) begin
            nxt_d.cnt = cur_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cnt_o     = cur_q.cnt;
    assign expired_o = (cur_q.cnt == LIMIT);

    // R7: the elapsed count never runs past the timeout limit
    assert_cnt_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt <= LIMIT);
endmodule

// File: rtl/pur_window.sv
`timescale 1ns/1ps
module pur_window #(
    parameter int BASE   = 20,
    parameter int STEP   = 3,
    parameter int TRIM_W = 3,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [TRIM_W-1:0] trim_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              late_o
);
    localparam int MAX_END = BASE + ((1 << TRIM_W) - 1) * STEP;

    typedef struct packed {
        logic [CNT_W-1:0] win_end;
    } win_t;

    win_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load_i) begin
            nxt_d.win_end = CNT_W'(BASE) + CNT_W'(trim_i) * CNT_W'(STEP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q.win_end <= CNT_W'(BASE);
        else        cur_q <= nxt_d;
    end

    assign late_o = (cnt_i >= cur_q.win_end);

    // R2: the captured window end stays between the base and the largest trim
    assert_end_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.win_end >= CNT_W'(BASE)) && (cur_q.win_end <= CNT_W'(MAX_END)));
endmodule

// File: rtl/pur_channel.sv
`timescale 1ns/1ps
module pur_channel #(
    parameter int BASE    = 20,
    parameter int STEP    = 3,
    parameter int TRIM_W  = 3,
    parameter int TIMEOUT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cross_i,
    input  logic              peak_i,
    input  logic [TRIM_W-1:0] trim_i,
    input  logic              enable_i,
    input  logic              read_i,
    output logic              flag_o
);
    import pur_pkg::*;

    localparam int CNT_W = $clog2(TIMEOUT + 1);

    pur_ctrl_t        cur_q, nxt_d;
    logic             start_d;
    logic             run_w;
    logic [CNT_W-1:0] cnt_w;
    logic             expired_w;
    logic             late_w;

    assign run_w = (cur_q.state == ST_OPEN);

    pur_timer #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(start_d), .run_i(run_w),
        .cnt_o(cnt_w), .expired_o(expired_w)
    );

    pur_window #(.BASE(BASE), .STEP(STEP), .TRIM_W(TRIM_W), .CNT_W(CNT_W)) u_window (
        .clk(clk), .rst_n(rst_n), .load_i(start_d), .trim_i(trim_i),
        .cnt_i(cnt_w), .late_o(late_w)
    );

    always_comb begin
        nxt_d   = cur_q;
        start_d = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (cross_i) begin
                    nxt_d.state = ST_OPEN;
                    start_d     = 1'b1;
                end
            end
            ST_OPEN: begin
                if (peak_i) begin
                    nxt_d.state = (!enable_i || !late_w) ? ST_HOLD : ST_IDLE;
                end else if (expired_w) begin
                    nxt_d.state = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (read_i) nxt_d.state = ST_IDLE;
            end
            default: nxt_d.state = ST_IDLE;
        endcase
        nxt_d.flag = (nxt_d.state == ST_HOLD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= ST_IDLE;
            cur_q.flag  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign flag_o = cur_q.flag;

    // R3: a flag only appears right after a sampled peak strobe
    assert_flag_after_peak_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(peak_i));

    // R4: a late peak under enable leaves no flag and an idle channel
    assert_late_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_OPEN && peak_i && enable_i && late_w)
        |=> (!flag_o && cur_q.state == ST_IDLE));

    // R5: the flag survives any cycle without a read
    assert_flag_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !read_i) |=> flag_o);

    // R6: with the test bypassed every peak in an open window is taken
    assert_bypass_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_OPEN && peak_i && !enable_i) |=> flag_o);

    // R7: an expired count with no peak closes the window
    assert_timeout_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_OPEN && expired_w && !peak_i) |=> (cur_q.state == ST_IDLE));
endmodule

// File: tb/pur_channel_bench.sv
`timescale 1ns/1ps
module pur_channel_bench;
    localparam int BASE    = 20;
    localparam int STEP    = 3;
    localparam int TRIM_W  = 3;
    localparam int TIMEOUT = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cross_i = 1'b0;
    logic              peak_i = 1'b0;
    logic [TRIM_W-1:0] trim_i = '0;
    logic              enable_i = 1'b1;
    logic              read_i = 1'b0;
    logic              flag_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string tag;
        logic  exp;
    } item_t;

    item_t q[$];
    event  sample_ev;

    always #2 clk = ~clk;

    pur_channel #(.BASE(BASE), .STEP(STEP), .TRIM_W(TRIM_W), .TIMEOUT(TIMEOUT)) u_pur_channel (
        .clk(clk), .rst_n(rst_n), .cross_i(cross_i), .peak_i(peak_i),
        .trim_i(trim_i), .enable_i(enable_i), .read_i(read_i), .flag_o(flag_o)
    );

    // monitor: pops expected items and compares with the flag output
    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (flag_o !== it.exp) begin
                    fails++;
                    $display("FAIL %s: flag_o=%b expected=%b", it.tag, flag_o, it.exp);
                end
            end
        end
    end

    task automatic expect_flag(input logic e, input string tag);
        item_t it;
        it.tag = tag;
        it.exp = e;
        q.push_back(it);
        -> sample_ev;
        #0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // crossing with trim tr, trim changed to tr2 afterwards, peak after k edges
    task automatic run_pulse(input logic [TRIM_W-1:0] tr, input logic [TRIM_W-1:0] tr2,
                             input int k, input logic en, input logic e, input string tag);
        @(negedge clk);
        enable_i = en;
        trim_i   = tr;
        cross_i  = 1'b1;
        @(negedge clk);
        cross_i  = 1'b0;
        trim_i   = tr2;
        if (k > 1) tick(k - 1);
        peak_i = 1'b1;
        @(negedge clk);
        peak_i = 1'b0;
        expect_flag(e, tag);
    endtask

    task automatic do_read(input string tag);
        read_i = 1'b1;
        @(negedge clk);
        read_i = 1'b0;
        expect_flag(1'b0, tag);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        expect_flag(1'b0, "R1 reset flag low");

        // R2/R3: trim 0 -> end 20, k=19 is inside
        run_pulse(3'd0, 3'd0, 19, 1'b1, 1'b1, "R3 trim0 k=19 accept");
        tick(5);
        expect_flag(1'b1, "R5 flag held without read");
        do_read("R5 read clears flag");

        // R4: k=20 at the edge is late; channel usable right after
        run_pulse(3'd0, 3'd0, 20, 1'b1, 1'b0, "R4 trim0 k=20 reject");
        run_pulse(3'd0, 3'd0, 5, 1'b1, 1'b1, "R4 new crossing right after reject");
        do_read("R5 read");

        // R2: trim 7 -> end 41; trim 3 -> end 29
        run_pulse(3'd7, 3'd7, 40, 1'b1, 1'b1, "R2 trim7 k=40 accept");
        do_read("R5 read");
        run_pulse(3'd7, 3'd7, 41, 1'b1, 1'b0, "R2 trim7 k=41 reject");
        run_pulse(3'd3, 3'd3, 28, 1'b1, 1'b1, "R2 trim3 k=28 accept");
        do_read("R5 read");
        run_pulse(3'd3, 3'd3, 29, 1'b1, 1'b0, "R2 trim3 k=29 reject");

        // R10: trim raised after the crossing does not widen the window
        run_pulse(3'd0, 3'd7, 25, 1'b1, 1'b0, "R10 trim change ignored");
        run_pulse(3'd7, 3'd0, 35, 1'b1, 1'b1, "R10 trim drop ignored");
        do_read("R5 read");

        // R6: bypass accepts late peaks, including k=TIMEOUT
        run_pulse(3'd0, 3'd0, 50, 1'b0, 1'b1, "R6 bypass k=50 accept");
        do_read("R5 read");
        run_pulse(3'd0, 3'd0, TIMEOUT, 1'b0, 1'b1, "R6 bypass k=TIMEOUT accept");
        do_read("R5 read");

        // R7: timeout returns to idle, later peak ignored
        run_pulse(3'd0, 3'd0, TIMEOUT + 1, 1'b0, 1'b0, "R7 bypass peak after timeout");
        run_pulse(3'd0, 3'd0, TIMEOUT + 3, 1'b1, 1'b0, "R7 peak after timeout");
        run_pulse(3'd0, 3'd0, 3, 1'b1, 1'b1, "R7 idle after timeout");
        do_read("R5 read");

        // R8: second crossing during an open window does not restart it
        @(negedge clk);
        enable_i = 1'b1; trim_i = 3'd0; cross_i = 1'b1;
        @(negedge clk);
        cross_i = 1'b0;
        tick(9);
        cross_i = 1'b1;
        @(negedge clk);
        cross_i = 1'b0;
        tick(11);
        peak_i = 1'b1;
        @(negedge clk);
        peak_i = 1'b0;
        expect_flag(1'b0, "R8 recross in window ignored (k=22 late)");
        tick(2);

        // R8: crossing while the flag is held leaves nothing after the read
        run_pulse(3'd0, 3'd0, 4, 1'b1, 1'b1, "R8 setup accept");
        cross_i = 1'b1;
        @(negedge clk);
        cross_i = 1'b0;
        do_read("R8 read after held crossing");
        peak_i = 1'b1;
        @(negedge clk);
        peak_i = 1'b0;
        expect_flag(1'b0, "R8 held crossing opened no window");
        tick(2);

        // R9: peak with the channel idle
        peak_i = 1'b1;
        @(negedge clk);
        peak_i = 1'b0;
        expect_flag(1'b0, "R9 idle peak ignored");
        tick(2);
        expect_flag(1'b0, "R9 flag still low");

        tick(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, flag_o=%b expected=completion", flag_o);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule